// File: doc/BRIEF.md
# Key-Guarded Two-Stage Watchdog

The block is a watchdog counter for a processor subsystem. A single 32-bit control word is written over a simple register write port. That word carries three fields: a reload count, a run/enable command bit and a 7-bit key. Each accepted write reloads the counter and either starts or stops it. The counter moves down by one on every pulse of a slow tick strobe, which runs at a few hundred hertz. It does not move on every clock.

Once the stored command bit is set, a refresh must prove that it knows the previous key. The key in the new write has to be the bitwise inverse of the stored key, so the accepted key alternates on every refresh. If the counter runs out, the block escalates in two steps. The first expiry raises a non-maskable interrupt and loads a short grace count. If the grace count also runs out before a valid refresh, the block raises a reset request. That request stays set until the block itself is reset.

Software can read back the stored control word and a status word. The status word holds the live count, the running flag, the interrupt and the reset request.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, nmi_o and rst_req_o are 0, the control readback (address CTRL_OFS, default 0x40) is 0 and the status readback (address STAT_OFS, default 0x44) is 0.
- R2: While the stored command bit (bit 8) is 0, a control write is accepted whatever its key (bits [15:9]), and the whole 32-bit word is stored.
- R3: While the stored command bit is 1, a control write whose key is not the 7-bit inverse of the stored key is ignored. The readback and the count are left unchanged.
- R4: While the stored command bit is 1, a control write whose key equals the 7-bit inverse of the stored key is accepted and stored.
- R5: An accepted write loads the count from bits [7:0]. A value of 0 loads 256. Status bits [8:0] hold the live count.
- R6: An accepted write with command bit 1 runs the counter, and the count falls by one per tick. With command bit 0 the counter stops and the count holds across ticks. Status bit 9 is the running flag.
- R7: When a running count of N has seen N ticks, nmi_o rises (status bit 10), the count reloads with GRACE (default 1) and the counter keeps running.
- R8: An accepted write clears a pending nmi_o and rearms the first stage.
- R9: An expiry while nmi_o is pending sets rst_req_o (status bit 11) and stops the counter. rst_req_o then stays 1, even across accepted writes, until rst_ni is asserted.
- R10: The count changes only on clock edges where tick_i is 1 or a write is accepted.
- R11: Reads of any other address return 0. Writes to any other address leave the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow tick strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 32 | Read data (combinational) |
| nmi_o | output | 1 | Non-maskable interrupt, first stage |
| rst_req_o | output | 1 | Sticky reset request, second stage |

## Verification
The key check is swept over all 128 candidate keys against one stored key. This shows that only the exact 7-bit inverse opens the register, and that every near miss leaves both the word and the live count untouched. The expiry path is run with the counts 1, 2, 3, 7, 100, 255 and 0. Each run checks that nmi_o stays low one tick before the expected edge and is high on it, which separates an off-by-one in the reload and the zero-means-256 case from correct behaviour. Separate runs of idle clocks without ticks, stopped-counter ticks, a refresh during the grace period and continued ticks after escalation distinguish tick gating, stop behaviour, interrupt clearing and the stickiness of the reset request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    STG_ARMED = 1'b0,
    STG_GRACE = 1'b1
  } wdg_stage_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8,
  parameter int KEY_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int EN_B   = CNT_W;
  localparam int KEY_LO = CNT_W + 1;
  localparam int KEY_HI = CNT_W + KEY_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [KEY_W-1:0]  old_key, new_key;
  logic              key_ok;

  assign old_key  = ctrl_q[KEY_HI:KEY_LO];
  assign new_key  = wdata_i[KEY_HI:KEY_LO];
  assign key_ok   = (new_key == ~old_key);
  assign accept_o = wr_i && (!ctrl_q[EN_B] || key_ok);
  assign ctrl_o   = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (accept_o) ctrl_q <= wdata_i;
  end

  AST_LOCKED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ctrl_q[EN_B] && (wdata_i[KEY_HI:KEY_LO] != ~ctrl_q[KEY_HI:KEY_LO])) |=> $stable(ctrl_q)); // R3
  AST_OPEN_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ctrl_q[EN_B]) |=> (ctrl_q == $past(wdata_i))); // R2
endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
  import wdg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int GRACE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_cnt_i,
  input  logic             ld_run_i,
  input  logic             tick_i,
  output logic [CNT_W:0]   cnt_o,
  output logic             run_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  localparam logic [CNT_W:0] FULL    = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] GRACE_C = (CNT_W+1)'(GRACE);
  localparam logic [CNT_W:0] ONE     = (CNT_W+1)'(1);

  logic [CNT_W:0] cnt_q;
  logic           run_q, rst_req_q;
  wdg_stage_e     stage_q;
  logic           step, expire;

  assign step   = run_q && tick_i;
  assign expire = step && (cnt_q <= ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      stage_q   <= STG_ARMED;
      rst_req_q <= 1'b0;
    end else if (ld_i) begin
      cnt_q   <= (ld_cnt_i == '0) ? FULL : {1'b0, ld_cnt_i};
      run_q   <= ld_run_i;
      stage_q <= STG_ARMED;
    end else if (expire) begin
      if (stage_q == STG_ARMED) begin
        stage_q <= STG_GRACE;
        cnt_q   <= GRACE_C;
      end else begin
        rst_req_q <= 1'b1;
        run_q     <= 1'b0;
        cnt_q     <= '0;
      end
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o     = cnt_q;
  assign run_o     = run_q;
  assign nmi_o     = (stage_q == STG_GRACE);
  assign rst_req_o = rst_req_q;

  AST_RST_REQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o); // R9
  AST_RST_AFTER_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(nmi_o)); // R9
  AST_NMI_CLEAR_BY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nmi_o) |-> $past(ld_i)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !tick_i) |=> $stable(cnt_o)); // R10
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !run_o) |=> $stable(cnt_o)); // R6
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= FULL); // R5
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top #(
  parameter int               DATA_W   = 32,
  parameter int               ADDR_W   = 8,
  parameter int               CNT_W    = 8,
  parameter int               KEY_W    = 7,
  parameter int               GRACE    = 1,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  localparam int ST_RUN = CNT_W + 1;
  localparam int ST_NMI = CNT_W + 2;
  localparam int ST_RST = CNT_W + 3;

  logic              ctrl_wr, accept;
  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W:0]    cnt;
  logic              run;

  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_OFS);

  wdg_key_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W)) i_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr),
    .wdata_i  (wr_data_i),
    .accept_o (accept),
    .ctrl_o   (ctrl_q)
  );

  wdg_escalate #(.CNT_W(CNT_W), .GRACE(GRACE)) i_esc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (accept),
    .ld_cnt_i  (wr_data_i[CNT_W-1:0]),
    .ld_run_i  (wr_data_i[CNT_W]),
    .tick_i    (tick_i),
    .cnt_o     (cnt),
    .run_o     (run),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_OFS) begin
      rd_data_o = ctrl_q;
    end else if (rd_addr_i == STAT_OFS) begin
      rd_data_o[CNT_W:0] = cnt;
      rd_data_o[ST_RUN]  = run;
      rd_data_o[ST_NMI]  = nmi_o;
      rd_data_o[ST_RST]  = rst_req_o;
    end
  end

  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i != CTRL_OFS)) |=> $stable(ctrl_q)); // R11
  AST_ACCEPT_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> ctrl_wr); // R11
endmodule

// File: tb/test_wdg_keyed_top.sv
`timescale 1ns/1ps
module test_wdg_keyed_top;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;
  localparam int GRACE = 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        nmi_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  wdg_keyed_top i_wdg_keyed_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] mk(int cnt, bit cmd, logic [6:0] key);
    return {16'h0, key, cmd, 8'(cnt)};
  endfunction

  function automatic logic [31:0] st(int cnt, bit run, bit nmi, bit rq);
    return {20'h0, rq, nmi, run, 9'(cnt)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    rd_addr_i = a;
    #0.5;
    v = rd_data_o;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, c;
    logic [6:0]  key;
    int          eff;
    int          nlist [7] = '{1, 2, 3, 7, 100, 255, 0};

    do_reset();
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); chk("R1 stat", v, 32'h0);
    chk("R1 outs", {30'h0, nmi_o, rst_req_o}, 32'h0);

    key = 7'h55;
    wr(A_CTRL, mk(10, 1, key));
    rd(A_CTRL, v); chk("R2 any key after reset", v, mk(10, 1, key));
    rd(A_STAT, v); chk("R5 R6 load run", v, st(10, 1, 0, 0));

    repeat (5) @(negedge clk_i);
    rd(A_STAT, v); chk("R10 no tick no count", v, st(10, 1, 0, 0));
    tk(3);
    rd(A_STAT, v); chk("R6 counts per tick", v, st(7, 1, 0, 0));

    for (int k = 0; k < 128; k++) begin
      if (7'(k) != ~key) begin
        wr(A_CTRL, mk(3, 1, 7'(k)));
        rd(A_CTRL, c); chk("R3 wrong key ctrl", c, mk(10, 1, key));
        rd(A_STAT, v); chk("R3 wrong key count", v, st(7, 1, 0, 0));
      end
    end

    wr(A_CTRL, mk(20, 1, ~key));
    key = ~key;
    rd(A_CTRL, v); chk("R4 inverse key accepted", v, mk(20, 1, key));
    rd(A_STAT, v); chk("R4 reload", v, st(20, 1, 0, 0));

    tk(19);
    chk("R7 no nmi before expiry", {31'h0, nmi_o}, 32'h0);
    tk(1);
    rd(A_STAT, v); chk("R7 nmi and grace", v, st(GRACE, 1, 1, 0));

    wr(A_CTRL, mk(4, 1, ~key));
    key = ~key;
    rd(A_STAT, v); chk("R8 write clears nmi", v, st(4, 1, 0, 0));

    tk(4);
    chk("R7 nmi again", {31'h0, nmi_o}, 32'h1);
    tk(GRACE);
    rd(A_STAT, v); chk("R9 reset request", v, st(0, 0, 1, 1));
    tk(3);
    chk("R9 sticky on ticks", {31'h0, rst_req_o}, 32'h1);
    wr(A_CTRL, mk(9, 1, ~key));
    rd(A_STAT, v); chk("R9 sticky across write", v, st(9, 1, 0, 1));

    do_reset();
    chk("R1 rst_req cleared", {31'h0, rst_req_o}, 32'h0);
    wr(A_CTRL, mk(10, 0, 7'h33));
    rd(A_STAT, v); chk("R6 stopped load", v, st(10, 0, 0, 0));
    tk(5);
    rd(A_STAT, v); chk("R6 stopped holds", v, st(10, 0, 0, 0));
    wr(A_CTRL, mk(6, 1, 7'h11));
    rd(A_CTRL, v); chk("R2 any key when disabled", v, mk(6, 1, 7'h11));

    rd(8'h48, v); chk("R11 unmapped read", v, 32'h0);
    wr(8'h48, mk(5, 1, 7'h6E));
    rd(A_CTRL, v); chk("R11 unmapped write", v, mk(6, 1, 7'h11));
    rd(A_STAT, v); chk("R11 count untouched", v, st(6, 1, 0, 0));

    foreach (nlist[i]) begin
      do_reset();
      wr(A_CTRL, mk(nlist[i], 1, 7'(nlist[i])));
      eff = (nlist[i] == 0) ? 256 : nlist[i];
      rd(A_STAT, v); chk("R5 count load", v, st(eff, 1, 0, 0));
      tk(eff - 1);
      rd(A_STAT, v); chk("R7 one tick before", v, st(1, 1, 0, 0));
      tk(1);
      rd(A_STAT, v); chk("R7 at expiry", v, st(GRACE, 1, 1, 0));
    end

    done = 1;
    finish_run();
  end
endmodule